// File: doc/BRIEF.md
# Serial Register Port with Sticky Read Selector

This block is the serial slave side of a small register map. A host drives a clock, an active-low frame strobe and a data line. Every frame carries a 16-bit word, most significant bit first. The top two bits of the word name a target and the low 14 bits are its payload. While the host shifts a word in, the block shifts a 16-bit word out on its own data line. The outgoing word comes from the source picked by a read selector, which sits in bits 7:6 of a control register written earlier.

The control register drives the rest of the chip in parallel and cannot be read back over the serial line. A 14-bit test register can be both written and read. The conversion result and the status word are parallel inputs that can only be read. Calibration storage lives outside the block. The block sends it write strobes, a pointer-clear strobe and a read-advance strobe, and it serialises the 14-bit value the calibration storage presents.

The serial inputs are brought into the system clock domain through synchronisers. Incoming bits are taken on rising serial-clock edges. Outgoing bits change on falling edges.

Top module: `sreg_port`

## Requirements
- R1: After reset, `ctrl_out` is all zeros, `dout` is 0, no calibration strobe is active, and the read selector is 00.
- R2: A word takes effect only after its 16th rising serial-clock edge inside one frame. A frame that ends earlier changes no register and raises no strobe.
- R3: Target 11 (word bits 15:14) loads word bits 13:0 into the control register, which appears on `ctrl_out`.
- R4: With selector 00 (control bits 7:6), the read word is four zero bits followed by the 12-bit `conv_result`, MSB first.
- R5: Target 00 loads the test register. With selector 01, the read word is two zero bits followed by the 14-bit test register.
- R6: With selector 11, the read word is `status_word` unchanged.
- R7: With selector 10, the read word is two zero bits followed by `cal_rd_data`. `cal_rd_next` pulses for one cycle after each complete frame that read this source, and never after a short frame.
- R8: The selector stays in force for every later frame until another complete target-11 word changes it.
- R9: Target 01 or 10 raises `cal_wr_en` for one cycle, with `cal_wr_addr` equal to the target and `cal_wr_data` equal to word bits 13:0.
- R10: A complete target-11 word raises `cal_ptr_clr` for one cycle and raises no `cal_wr_en`.
- R11: Serial-clock edges after the 16th edge of a frame are ignored. A frame commits at most once.
- R12: The read word is captured when the frame opens. Its MSB is on `dout` before the first rising edge, and `dout` moves to the next bit only after a falling serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| sync_n | input | 1 | Active-low frame strobe |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out |
| conv_result | input | 12 | Latest conversion result |
| status_word | input | 16 | Status word |
| ctrl_out | output | 14 | Control register contents |
| cal_wr_en | output | 1 | One-cycle calibration write strobe |
| cal_wr_addr | output | 2 | Target that produced the calibration write |
| cal_wr_data | output | 14 | Calibration write payload |
| cal_ptr_clr | output | 1 | One-cycle calibration pointer clear |
| cal_rd_data | input | 14 | Calibration value currently selected for reading |
| cal_rd_next | output | 1 | One-cycle advance after a calibration read |

## Verification
Each serial input passes two synchroniser stages and one edge register. A host-side edge therefore acts on block state about three system clocks later, and commit strobes appear one clock after that. The bench holds every serial-clock phase for six system clocks. It samples `dout` three clocks after setting up each bit, just before the rising edge, and it reads `ctrl_out` and the strobe counters at least ten clocks after the frame closes, so every result has settled before it is compared. Strobes are counted by a monitor on the falling system-clock edge. This lets the bench confirm exact pulse counts per frame, as well as the absence of pulses after short frames.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   localparam int TGT_W = 2;

   typedef enum logic [TGT_W-1:0] {
      TGT_TEST  = 2'b00,
      TGT_CAL_A = 2'b01,
      TGT_CAL_B = 2'b10,
      TGT_CTRL  = 2'b11
   } tgt_e;

   typedef enum logic [1:0] {
      SRC_RESULT = 2'b00,
      SRC_TEST   = 2'b01,
      SRC_CAL    = 2'b10,
      SRC_STATUS = 2'b11
   } src_e;

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int   W       = 1,
   parameter int   STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sreg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d_in;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sreg_rx.sv
module sreg_rx #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_act,
   input  logic               bit_rise,
   input  logic               din_s,
   output logic               commit,
   output logic [FRAME_W-1:0] word
);

   localparam int CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         word   <= '0;
         commit <= 1'b0;
      end else if (!frame_act) begin
         cnt    <= '0;
         commit <= 1'b0;
      end else if (bit_rise && cnt != FULL) begin
         word   <= {word[FRAME_W-2:0], din_s};
         cnt    <= cnt + 1'b1;
         commit <= (cnt == LAST);
      end else begin
         commit <= 1'b0;
      end
   end

   AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);  // R11
   AST_COMMIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(frame_act));  // R2

endmodule

// File: rtl/sreg_rdmux.sv
module sreg_rdmux
   import sreg_pkg::*;
#(
   parameter int FRAME_W = 16,
   parameter int DATA_W  = 14,
   parameter int RES_W   = 12
) (
   input  src_e               sel,
   input  logic [RES_W-1:0]   result,
   input  logic [FRAME_W-1:0] status,
   input  logic [DATA_W-1:0]  test_val,
   input  logic [DATA_W-1:0]  cal_val,
   output logic [FRAME_W-1:0] word
);

   logic [FRAME_W-1:0] res_w, test_w, cal_w;

   generate
      if (RES_W == FRAME_W) begin : g_res_full
         assign res_w = result;
      end else begin : g_res_pad
         assign res_w = {{(FRAME_W-RES_W){1'b0}}, result};
      end
      if (DATA_W == FRAME_W) begin : g_dat_full
         assign test_w = test_val;
         assign cal_w  = cal_val;
      end else begin : g_dat_pad
         assign test_w = {{(FRAME_W-DATA_W){1'b0}}, test_val};
         assign cal_w  = {{(FRAME_W-DATA_W){1'b0}}, cal_val};
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SRC_RESULT: word = res_w;
         SRC_TEST:   word = test_w;
         SRC_CAL:    word = cal_w;
         default:    word = status;
      endcase
   end

endmodule

// File: rtl/sreg_tx.sv
module sreg_tx #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_word,
   input  logic               shift,
   output logic               dout
);

   logic [FRAME_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '0;
      else if (load)  sh <= load_word;
      else if (shift) sh <= {sh[FRAME_W-2:0], 1'b0};
   end

   assign dout = sh[FRAME_W-1];

   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !shift) |=> $stable(dout));  // R12

endmodule

// File: rtl/sreg_port.sv
module sreg_port
   import sreg_pkg::*;
#(
   parameter int FRAME_W     = 16,
   parameter int RES_W       = 12,
   parameter int SEL_LO      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sclk,
   input  logic                        sync_n,
   input  logic                        din,
   output logic                        dout,
   input  logic [RES_W-1:0]            conv_result,
   input  logic [FRAME_W-1:0]          status_word,
   output logic [FRAME_W-TGT_W-1:0]    ctrl_out,
   output logic                        cal_wr_en,
   output logic [TGT_W-1:0]            cal_wr_addr,
   output logic [FRAME_W-TGT_W-1:0]    cal_wr_data,
   output logic                        cal_ptr_clr,
   input  logic [FRAME_W-TGT_W-1:0]    cal_rd_data,
   output logic                        cal_rd_next
);

   localparam int DATA_W = FRAME_W - TGT_W;

   generate
      if (RES_W > FRAME_W) begin : g_bad_res
         $error("sreg_port: RES_W exceeds FRAME_W");
      end
      if (SEL_LO + 1 >= DATA_W) begin : g_bad_sel
         $error("sreg_port: selector field outside the control word");
      end
      if (FRAME_W < 4) begin : g_bad_frame
         $error("sreg_port: FRAME_W too small");
      end
   endgenerate

   // synchronised serial pins: bit 2 = sync_n, bit 1 = sclk, bit 0 = din
   logic [2:0] pins_s;
   logic [1:0] edge_prev;

   sreg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({sync_n, sclk, din}),
      .q     (pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) edge_prev <= 2'b10;
      else        edge_prev <= pins_s[2:1];
   end

   logic frame_act, frame_open, bit_rise, bit_fall;
   assign frame_act  = ~pins_s[2];
   assign frame_open = ~pins_s[2] &  edge_prev[1];
   assign bit_rise   =  pins_s[1] & ~edge_prev[0];
   assign bit_fall   = ~pins_s[1] &  edge_prev[0] & frame_act;

   logic               commit;
   logic [FRAME_W-1:0] rx_word;

   sreg_rx #(.FRAME_W(FRAME_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_act (frame_act),
      .bit_rise  (bit_rise),
      .din_s     (pins_s[0]),
      .commit    (commit),
      .word      (rx_word)
   );

   logic [DATA_W-1:0] ctrl_q, test_q;
   src_e              rd_sel, frame_sel;
   tgt_e              rx_tgt;
   logic [DATA_W-1:0] rx_data;
   logic [FRAME_W-1:0] rd_word;

   assign rd_sel  = src_e'(ctrl_q[SEL_LO+1:SEL_LO]);
   assign rx_tgt  = tgt_e'(rx_word[FRAME_W-1 -: TGT_W]);
   assign rx_data = rx_word[DATA_W-1:0];

   sreg_rdmux #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .RES_W(RES_W)) u_mux (
      .sel      (rd_sel),
      .result   (conv_result),
      .status   (status_word),
      .test_val (test_q),
      .cal_val  (cal_rd_data),
      .word     (rd_word)
   );

   sreg_tx #(.FRAME_W(FRAME_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (frame_open),
      .load_word (rd_word),
      .shift     (bit_fall),
      .dout      (dout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         test_q      <= '0;
         frame_sel   <= SRC_RESULT;
         cal_wr_en   <= 1'b0;
         cal_wr_addr <= '0;
         cal_wr_data <= '0;
         cal_ptr_clr <= 1'b0;
         cal_rd_next <= 1'b0;
      end else begin
         cal_wr_en   <= 1'b0;
         cal_ptr_clr <= 1'b0;
         cal_rd_next <= 1'b0;
         if (frame_open) frame_sel <= rd_sel;
         if (commit) begin
            cal_rd_next <= (frame_sel == SRC_CAL);
            case (rx_tgt)
               TGT_CTRL: begin
                  ctrl_q      <= rx_data;
                  cal_ptr_clr <= 1'b1;
               end
               TGT_TEST: test_q <= rx_data;
               default: begin
                  cal_wr_en   <= 1'b1;
                  cal_wr_addr <= rx_tgt;
                  cal_wr_data <= rx_data;
               end
            endcase
         end
      end
   end

   assign ctrl_out = ctrl_q;

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(ctrl_q));  // R3
   AST_SEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(rd_sel));  // R8
   AST_CAL_WR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      cal_wr_en |-> $past(commit));  // R9
   AST_CLR_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      cal_ptr_clr |-> !cal_wr_en);  // R10
   AST_RDNEXT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      cal_rd_next |-> (frame_sel == SRC_CAL));  // R7

endmodule

// File: tb/sreg_port_test.sv
module sreg_port_test;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0, sclk = 1'b0, sync_n = 1'b1, din = 1'b0;
   logic        dout;
   logic [11:0] conv_result = '0;
   logic [15:0] status_word = '0;
   logic [13:0] ctrl_out, cal_wr_data, cal_rd_data = '0;
   logic        cal_wr_en, cal_ptr_clr, cal_rd_next;
   logic [1:0]  cal_wr_addr;

   sreg_port uut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
      .dout(dout), .conv_result(conv_result), .status_word(status_word),
      .ctrl_out(ctrl_out), .cal_wr_en(cal_wr_en), .cal_wr_addr(cal_wr_addr),
      .cal_wr_data(cal_wr_data), .cal_ptr_clr(cal_ptr_clr),
      .cal_rd_data(cal_rd_data), .cal_rd_next(cal_rd_next)
   );

   int checks = 0, fails = 0;
   int wr_cnt = 0, clr_cnt = 0, nxt_cnt = 0;
   logic [1:0]  wr_addr_seen = '0;
   logic [13:0] wr_data_seen = '0;

   always @(negedge clk) begin
      if (cal_wr_en) begin
         wr_cnt++;
         wr_addr_seen = cal_wr_addr;
         wr_data_seen = cal_wr_data;
      end
      if (cal_ptr_clr) clr_cnt++;
      if (cal_rd_next) nxt_cnt++;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] exp_word(input logic [1:0] sel, input logic [11:0] res,
                                            input logic [15:0] st, input logic [13:0] tst,
                                            input logic [13:0] cal);
      case (sel)
         2'b00:   return {4'b0000, res};
         2'b01:   return {2'b00, tst};
         2'b10:   return {2'b00, cal};
         default: return st;
      endcase
   endfunction

   task automatic xfer(input logic [15:0] wr, input int nbits, input bit flip,
                       output logic [15:0] rd);
      rd = '0;
      sync_n = 1'b0;
      waitc(6);
      for (int i = 0; i < nbits; i++) begin
         din = (i < 16) ? wr[15-i] : 1'($urandom);
         waitc(3);
         if (i < 16) rd[15-i] = dout;
         sclk = 1'b1;
         waitc(6);
         sclk = 1'b0;
         if (flip && i == 4) status_word = ~status_word;
         waitc(3);
      end
      waitc(3);
      sync_n = 1'b1;
      waitc(10);
   endtask

   logic [13:0] test_m = '0, ctrl_m = '0;
   logic [15:0] rd, ex;
   int w0, c0, n0;

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0C3A));
      waitc(4);
      rst_n = 1'b1;
      waitc(4);
      // R1 reset state
      check("R1 ctrl_out", 32'(ctrl_out), 32'h0);
      check("R1 dout", 32'(dout), 32'h0);
      check("R1 strobes", 32'(wr_cnt + clr_cnt + nxt_cnt), 32'h0);

      // R4 default selector returns padded result; test reg written alongside
      conv_result = 12'hA5C;
      xfer({2'b00, 14'h1234}, 16, 0, rd);
      check("R4 result word", 32'(rd), 32'h0A5C);
      test_m = 14'h1234;

      // R3 / R10 control write, selector 01
      ctrl_m = 14'h2A7F;
      xfer({2'b11, ctrl_m}, 16, 0, rd);
      check("R3 ctrl_out", 32'(ctrl_out), 32'(ctrl_m));
      check("R10 clr pulse", 32'(clr_cnt), 32'd1);
      check("R10 no cal write", 32'(wr_cnt), 32'd0);

      // R5 / R8 test readback, selector still 01
      xfer({2'b00, 14'h3FFF}, 16, 0, rd);
      check("R5 R8 test word", 32'(rd), {18'b0, test_m});
      test_m = 14'h3FFF;
      xfer({2'b00, test_m}, 16, 0, rd);
      check("R5 test word", 32'(rd), 32'h3FFF);

      // R2 short frames change nothing
      xfer({2'b00, 14'h0001}, 10, 0, rd);
      xfer({2'b11, 14'h00C0}, 7, 0, rd);
      check("R2 ctrl kept", 32'(ctrl_out), 32'(ctrl_m));
      xfer({2'b00, test_m}, 16, 0, rd);
      check("R2 test kept", 32'(rd), 32'h3FFF);
      check("R2 no clr", 32'(clr_cnt), 32'd1);

      // R11 extra edges ignored
      c0 = clr_cnt;
      xfer({2'b00, 14'h0ABC}, 21, 0, rd);
      test_m = 14'h0ABC;
      xfer({2'b00, test_m}, 16, 0, rd);
      check("R11 test value", 32'(rd), 32'h0ABC);
      check("R11 no stray strobe", 32'(wr_cnt + clr_cnt - c0), 32'd0);

      // R6 / R12 status selected, status changes mid-frame
      ctrl_m = 14'h00C0;
      xfer({2'b11, ctrl_m}, 16, 0, rd);
      status_word = 16'hC3A5;
      xfer({2'b00, test_m}, 16, 1, rd);
      check("R6 R12 status word", 32'(rd), 32'hC3A5);

      // R9 calibration writes
      w0 = wr_cnt;
      xfer({2'b01, 14'h1111}, 16, 0, rd);
      check("R9 count a", 32'(wr_cnt - w0), 32'd1);
      check("R9 addr a", 32'(wr_addr_seen), 32'h1);
      check("R9 data a", 32'(wr_data_seen), 32'h1111);
      xfer({2'b10, 14'h2E0D}, 16, 0, rd);
      check("R9 addr b", 32'(wr_addr_seen), 32'h2);
      check("R9 data b", 32'(wr_data_seen), 32'h2E0D);

      // R7 calibration read source
      ctrl_m = 14'h0080;
      xfer({2'b11, ctrl_m}, 16, 0, rd);
      cal_rd_data = 14'h2BCD;
      n0 = nxt_cnt;
      xfer({2'b00, test_m}, 16, 0, rd);
      check("R7 cal word", 32'(rd), 32'h2BCD);
      check("R7 advance", 32'(nxt_cnt - n0), 32'd1);
      xfer({2'b00, test_m}, 9, 0, rd);
      check("R7 no advance on short", 32'(nxt_cnt - n0), 32'd1);

      // random frames against the model
      for (int k = 0; k < 48; k++) begin
         int op;
         logic [13:0] d;
         logic [1:0]  tg;
         op = int'($urandom % 4);
         d  = 14'($urandom);
         conv_result = 12'($urandom);
         status_word = 16'($urandom);
         cal_rd_data = 14'($urandom);
         ex = exp_word(ctrl_m[7:6], conv_result, status_word, test_m, cal_rd_data);
         w0 = wr_cnt;
         n0 = nxt_cnt;
         case (op)
            0: tg = 2'b00;
            1: tg = 2'b01;
            2: tg = 2'b10;
            default: tg = 2'b11;
         endcase
         xfer({tg, d}, 16, 0, rd);
         check("R4 R5 R6 R7 R8 random read", 32'(rd), 32'(ex));
         check("R7 random advance", 32'(nxt_cnt - n0), (ctrl_m[7:6] == 2'b10) ? 32'd1 : 32'd0);
         if (tg == 2'b00) test_m = d;
         if (tg == 2'b11) ctrl_m = d;
         if (tg == 2'b01 || tg == 2'b10) begin
            check("R9 random write", {wr_cnt - w0 == 1, 14'(wr_data_seen), 2'(wr_addr_seen)},
                  {1'b1, d, tg});
         end else begin
            check("R9 R10 random no write", 32'(wr_cnt - w0), 32'd0);
         end
         check("R3 random ctrl", 32'(ctrl_out), 32'(ctrl_m));
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule